// File: doc/BRIEF.md
# Single-Beat Read Response Sequencer

This block turns one processor-bus read of one to four bytes, aimed at PCI memory, I/O, configuration or interrupt-acknowledge space, into a PCI request. It then translates what the PCI side reports into the response the processor bus expects. While the read is open, the requester is held with a wait signal. The PCI engine itself is outside the block. It is seen only as a request line, a one-cycle completion strobe with a three-bit outcome code, and a read data word.

The outcome selects one of three processor-bus actions:
- A retry sends the transaction back for rearbitration.
- An accept, or a blind disconnect on the final beat, latches the data and acknowledges the address and data.
- A target or master abort drops wait and raises the master-error line of the master that asked.

A successful read is not acknowledged until the posted-write logic reports its buffers flushed. Line (burst) reads are not supported and draw no response.

Top module: `rd_resp_seq`

## Requirements
- R1: In the idle state, a request with `req_valid`=1 and `req_line`=0 is captured at the clock edge. `bus_wait` is 1 in the following cycle and `pci_req` stays 0 in that cycle.
- R2: `pci_req` rises one cycle after `bus_wait` and stays high until the edge at which `pci_done` is seen. `bus_wait` stays high from capture until the terminal response cycle.
- R3: Outcome code 0 (retry) gives a one-cycle `rearb` pulse in the cycle after `pci_done`, with `bus_wait` low and no acknowledge or master error.
- R4: Outcome codes 1 (accept) and 2 (blind disconnect) latch `pci_rdata` at the `pci_done` edge. `addr_ack` and `rd_dack` then pulse together for one cycle, with `rd_data` equal to the latched word.
- R5: After a successful outcome, `bus_wait` stays high until `flush_done` is seen high at a clock edge (the first such edge is one cycle after `pci_done`). The acknowledge follows in the next cycle.
- R6: Outcome codes 3 (target abort), 4 (master abort) and 5 to 7 give a one-cycle pulse on `merr`, in the cycle after `pci_done`. Only bit `req_master` (as captured) is set, and `bus_wait` is low.
- R7: A request with `req_line`=1 is ignored: `bus_wait`, `pci_req` and all responses stay low.
- R8: The cycle after any terminal response is idle, and a request present in that cycle is captured.
- R9: `req_valid` while a read is open, and `pci_done` outside the PCI request phase, have no effect.
- R10: While `rst_n` is low, all outputs except `rd_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor-bus read request present |
| req_line | input | 1 | Request is a line (burst) read |
| req_master | input | MID_W | ID of the requesting master |
| flush_done | input | 1 | Posted-write buffers are empty |
| pci_req | output | 1 | Request to the PCI engine |
| pci_done | input | 1 | PCI engine outcome strobe |
| pci_result | input | 3 | Outcome code (0 retry, 1 accept, 2 blind disconnect, 3 target abort, 4 master abort) |
| pci_rdata | input | DATA_W | PCI read data, valid with `pci_done` |
| bus_wait | output | 1 | Hold the requester |
| rearb | output | 1 | Rearbitrate the transaction |
| addr_ack | output | 1 | Address acknowledge |
| rd_dack | output | 1 | Read data acknowledge |
| rd_data | output | DATA_W | Read data returned to the processor bus |
| merr | output | MASTERS | One-hot master-error pulse |

## Verification
The read is run with each outcome code. This shows that retry, both success codes and the abort family go to different responses, and that the abort pulse lands on the bit of the master that asked. Success cases are run with `flush_done` already high and with it rising several cycles late, which shows whether the acknowledge is gated by the flush. Line reads, requests and strobes arriving while a read is open, and a request held high across a terminal cycle show what must be ignored and when a new read can be accepted.

// File: rtl/rd_resp_seq.sv
module rd_resp_seq #(
  parameter int MASTERS = 4,
  parameter int DATA_W = 32,
  localparam int MID_W = (MASTERS > 1) ? $clog2(MASTERS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_line,
  input  logic [MID_W-1:0]  req_master,
  input  logic              flush_done,
  output logic              pci_req,
  input  logic              pci_done,
  input  logic [2:0]        pci_result,
  input  logic [DATA_W-1:0] pci_rdata,
  output logic              bus_wait,
  output logic              rearb,
  output logic              addr_ack,
  output logic              rd_dack,
  output logic [DATA_W-1:0] rd_data,
  output logic [MASTERS-1:0] merr
);

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_PCI, S_DRAIN, S_ACK, S_RETRY, S_ERR
  } st_t;

  st_t              st, st_nx;
  logic [MID_W-1:0] mid_q;
  logic [DATA_W-1:0] data_q;

  wire take  = (st == S_IDLE) && req_valid && !req_line;
  wire ok_rs = (pci_result == 3'd1) || (pci_result == 3'd2);

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (take) st_nx = S_HOLD;
      S_HOLD:  st_nx = S_PCI;
      S_PCI:   if (pci_done) st_nx = (pci_result == 3'd0) ? S_RETRY : (ok_rs ? S_DRAIN : S_ERR);
      S_DRAIN: if (flush_done) st_nx = S_ACK;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else        st <= st_nx;
  end

  always_ff @(posedge clk) begin
    if (take) mid_q <= req_master;
    if (st == S_PCI && pci_done && ok_rs) data_q <= pci_rdata;
  end

  assign bus_wait = (st == S_HOLD) || (st == S_PCI) || (st == S_DRAIN);
  assign pci_req  = (st == S_PCI);
  assign rearb    = (st == S_RETRY);
  assign addr_ack = (st == S_ACK);
  assign rd_dack  = (st == S_ACK);
  assign rd_data  = data_q;
  assign merr     = (st == S_ERR) ? (MASTERS'(1) << mid_q) : '0;

  a_r1_capture: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> bus_wait && !pci_req);
  a_r7_line_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req_valid && req_line) |=> !bus_wait);
  a_r2_req_under_wait: assert property (@(posedge clk) disable iff (!rst_n)
    pci_req |-> bus_wait);
  a_r5_ack_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |-> $past(flush_done));
  a_r4_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |-> $stable(rd_data));
  a_r3_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({addr_ack, rearb, |merr}));
  a_r6_merr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(merr));
  a_r6_merr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|merr) |=> merr == '0);
  a_r8_back_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_ack || rearb || (|merr)) |=> !pci_req && !addr_ack && !rearb && merr == '0);

endmodule

// File: tb/rd_resp_seq_tb.sv
module rd_resp_seq_tb;
  localparam int M = 4;
  localparam int DW = 32;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_line = 0, flush_done = 0, pci_done = 0;
  logic [1:0] req_master = 0;
  logic [2:0] pci_result = 0;
  logic [DW-1:0] pci_rdata = 0;
  logic pci_req, bus_wait, rearb, addr_ack, rd_dack;
  logic [DW-1:0] rd_data;
  logic [M-1:0] merr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rd_resp_seq #(.MASTERS(M), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
    .req_master(req_master), .flush_done(flush_done), .pci_req(pci_req),
    .pci_done(pci_done), .pci_result(pci_result), .pci_rdata(pci_rdata),
    .bus_wait(bus_wait), .rearb(rearb), .addr_ack(addr_ack), .rd_dack(rd_dack),
    .rd_data(rd_data), .merr(merr));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: phase 0 idle,1 hold,2 pci,3 flush wait,4 ack,5 retry,6 error
  int ph = 0;
  int mid = 0;
  logic [DW-1:0] mdata = 0;

  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else begin
      case (ph)
        0: if (req_valid && !req_line) begin mid = int'(req_master); ph = 1; end
        1: ph = 2;
        2: if (pci_done) begin
             if (pci_result == 0) ph = 5;
             else if (pci_result == 1 || pci_result == 2) begin mdata = pci_rdata; ph = 3; end
             else ph = 6;
           end
        3: if (flush_done) ph = 4;
        default: ph = 0;
      endcase
    end
    #2;
    if (rst_n && !done) begin
      chk("R1/R2 bus_wait", 64'(bus_wait), 64'(ph >= 1 && ph <= 3));
      chk("R2 pci_req", 64'(pci_req), 64'(ph == 2));
      chk("R3 rearb", 64'(rearb), 64'(ph == 5));
      chk("R4/R5 addr_ack", 64'(addr_ack), 64'(ph == 4));
      chk("R4/R5 rd_dack", 64'(rd_dack), 64'(ph == 4));
      chk("R6 merr", 64'(merr), (ph == 6) ? 64'(1) << mid : 64'd0);
      if (ph == 4) chk("R4 rd_data", 64'(rd_data), 64'(mdata));
    end
  end

  int dn = 0;
  task automatic rd(input int m, input int code, input int lat, input int fl);
    @(negedge clk);
    req_valid = 1; req_line = 0; req_master = 2'(m); flush_done = (fl == 0);
    @(negedge clk);
    req_valid = 0;
    while (!pci_req) @(negedge clk);
    repeat (lat) @(negedge clk);
    dn++;
    pci_done = 1; pci_result = 3'(code); pci_rdata = 32'hA5C3_0000 + 32'(dn * 17);
    @(negedge clk);
    pci_done = 0;
    if (fl > 0) begin
      repeat (fl - 1) @(negedge clk);
      flush_done = 1;
    end
    repeat (3) @(negedge clk);
    chk("R8 idle after response", 64'(bus_wait), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 reset wait", 64'(bus_wait), 0);
    chk("R10 reset pci_req", 64'(pci_req), 0);
    chk("R10 reset responses", 64'({rearb, addr_ack, rd_dack, merr}), 0);
    rst_n = 1;
    @(negedge clk);

    rd(2, 1, 0, 0);
    rd(1, 0, 2, 0);
    rd(3, 2, 1, 4);
    rd(0, 1, 3, 1);
    rd(1, 3, 0, 0);
    rd(3, 4, 2, 0);
    rd(0, 6, 1, 0);
    rd(2, 2, 0, 7);

    // R7: line read ignored
    @(negedge clk);
    req_valid = 1; req_line = 1; req_master = 2;
    repeat (3) begin
      @(negedge clk);
      chk("R7 line read wait", 64'(bus_wait), 0);
      chk("R7 line read pci_req", 64'(pci_req), 0);
    end
    req_valid = 0; req_line = 0;

    // R9: request and strobe while busy
    @(negedge clk);
    req_valid = 1; req_master = 1; flush_done = 1;
    @(negedge clk);
    req_valid = 1; req_master = 3; pci_done = 1; pci_result = 3;
    @(negedge clk);
    req_valid = 0; pci_done = 0;
    chk("R9 stray strobe ignored", 64'(pci_req), 1);
    @(negedge clk);
    pci_done = 1; pci_result = 4;
    @(negedge clk);
    pci_done = 0;
    chk("R9 error goes to first master", 64'(merr), 64'(4'b0010));
    repeat (2) @(negedge clk);

    // R8: request held through a terminal cycle is re-accepted
    req_valid = 1; req_master = 0;
    @(negedge clk);
    while (!pci_req) @(negedge clk);
    pci_done = 1; pci_result = 0;
    @(negedge clk);
    pci_done = 0;
    chk("R8 retry pulse", 64'(rearb), 1);
    @(negedge clk);
    chk("R8 idle cycle", 64'(bus_wait), 0);
    @(negedge clk);
    chk("R8 re-accepted", 64'(bus_wait), 1);
    req_valid = 0;
    while (!pci_req) @(negedge clk);
    pci_done = 1; pci_result = 1;
    @(negedge clk);
    pci_done = 0;
    repeat (4) @(negedge clk);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule